// File: doc/BRIEF.md
# Power-Fail Gated Bank Chip-Enable Decoder

This block steers a single active-low chip-enable onto one of four active-low bank chip-enables. A two-bit bank select chooses the bank. The select and the enable path are transparent: while power is good, a selected output follows the enable input in the same cycle. The block also takes a digital power-fail flag from an external supply monitor and uses it to write-protect all banks.

When the flag rises, an access that is already under way may finish, for a bounded number of cycles. After that, every output is held inactive. When the flag falls again, the outputs stay inactive for a recovery interval before normal decoding resumes. This gives a processor time to settle before memory can be written again. Both intervals are parameters counted in clock cycles. All inputs are assumed to be synchronous to `clk`.

Top module: `nvbank_ce_guard`

## Requirements
- R1: While protection is off and `ce_n_i` is low, output bit `ce_o_n[k]` is low and the other three are high, where k is the value of `sel_i` (bit 0 is the least significant bit): 0 selects bit 0, 1 selects bit 1, 2 selects bit 2 and 3 selects bit 3.
- R2: Whenever `ce_n_i` is high, all four outputs are high, whatever `sel_i` holds.
- R3: At no time is more than one output low.
- R4: If `pf_det_i` is sampled high on a clock edge while `ce_n_i` is high, all outputs are high from that edge on, whatever `ce_n_i` and `sel_i` do.
- R5: If `pf_det_i` is sampled high while `ce_n_i` is low, the outputs keep following `ce_n_i` until the first edge at which `ce_n_i` is sampled high. From that edge on, all outputs are high.
- R6: If that access is still running, the outputs follow `ce_n_i` only for the states after edges 1 to `WP_CYC`, counted from the edge that first sampled `pf_det_i` high. From edge `WP_CYC`+1 on, all outputs are high.
- R7: Once protection is in force, it stays in force for as long as `pf_det_i` is high, even if a new access is requested.
- R8: The first edge that samples `pf_det_i` low after protection counts as edge 1. Outputs stay high through edge `REC_CYC` and follow the decode again from edge `REC_CYC`+1.
- R9: If `pf_det_i` is sampled high during recovery, protection returns. The next low sample starts a full `REC_CYC` recovery count from the beginning.
- R10: Synchronous active-low reset `rst_n` puts the block in normal decoding with no protection. After it is released, a low `ce_n_i` selects a bank in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pf_det_i | input | 1 | Power-fail flag from the supply monitor, high while supply is out of tolerance |
| ce_n_i | input | 1 | Incoming chip-enable, active low |
| sel_i | input | SEL_W (2) | Bank select, bit 0 least significant |
| ce_o_n | output | NUM_BANKS (4) | Conditioned bank chip-enables, active low |

## Verification
The decode is tried with all four select values under a low enable, which tells a swapped or stuck select bit apart from a correct one. It is also tried with a high enable on every select, which exposes any output that leaks through when idle. Power-fail is raised in two ways: with no access running, and with an access running. The running access either ends early or is held past the timeout, and reading the output on the exact edges `WP_CYC` and `WP_CYC`+1 shows an off-by-one in the drain count. Recovery is measured on edges `REC_CYC` and `REC_CYC`+1, once cleanly and once after the flag bounces mid-count, which separates a restart of the count from a resumed count.

// File: rtl/nvbank_pkg.sv
// Package: shared types for the power-fail gated bank chip-enable decoder.
// Assumes: nothing; pure type definitions.
package nvbank_pkg;

    // Protection controller states.
    typedef enum logic [1:0] {
        GUARD_RUN     = 2'd0,  // normal decoding
        GUARD_DRAIN   = 2'd1,  // power failing, letting current access finish
        GUARD_LOCK    = 2'd2,  // all banks write-protected
        GUARD_RECOVER = 2'd3   // power back, waiting out recovery interval
    } guard_state_t;

endpackage

// File: rtl/nvbank_cycle_timer.sv
// Module: nvbank_cycle_timer
// Counts clock cycles up to a limit that the caller supplies, and flags the last count.
// Assumes: limit_i >= 1 and stable while en_i is high; clr_i takes priority over en_i.
module nvbank_cycle_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: hold the running cycle count; clear on request, otherwise step while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: signal that the current cycle is the final one of the interval.
    always_comb begin
        last_o = (cnt_q == limit_i - 1'b1);
    end

    // R6 / R8: the count never runs past its limit while counting.
    assert_count_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (cnt_q < limit_i));

endmodule

// File: rtl/nvbank_guard_fsm.sv
// Module: nvbank_guard_fsm
// Tracks power state and decides whether the bank decoder may pass the chip-enable.
// Assumes: pf_det_i and ce_n_i are synchronous to clk; WP_CYC and REC_CYC are >= 1.
module nvbank_guard_fsm
    import nvbank_pkg::*;
#(
    parameter int WP_CYC  = 1000,
    parameter int REC_CYC = 800000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pf_det_i,
    input  logic ce_n_i,
    output logic pass_o,
    output guard_state_t state_o
);

    localparam int MAX_CYC = (WP_CYC > REC_CYC) ? WP_CYC : REC_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    guard_state_t state_q;
    guard_state_t state_d;
    logic [CNT_W-1:0] limit;
    logic tmr_clr;
    logic tmr_en;
    logic tmr_last;

    // Purpose: pick the interval length that belongs to the state being timed.
    always_comb begin
        limit = (state_q == GUARD_DRAIN) ? CNT_W'(WP_CYC) : CNT_W'(REC_CYC);
    end

    nvbank_cycle_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tmr_clr),
        .en_i    (tmr_en),
        .limit_i (limit),
        .last_o  (tmr_last)
    );

    // Purpose: next-state rules for drain, lock and recovery.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GUARD_RUN: begin
                if (pf_det_i) state_d = ce_n_i ? GUARD_LOCK : GUARD_DRAIN;
            end
            GUARD_DRAIN: begin
                if (ce_n_i || tmr_last) state_d = GUARD_LOCK;
            end
            GUARD_LOCK: begin
                if (!pf_det_i) state_d = GUARD_RECOVER;
            end
            GUARD_RECOVER: begin
                if (pf_det_i)      state_d = GUARD_LOCK;
                else if (tmr_last) state_d = GUARD_RUN;
            end
            default: state_d = GUARD_LOCK;
        endcase
    end

    // Purpose: timer restarts on every state change and counts only in timed states.
    always_comb begin
        tmr_clr = (state_d != state_q);
        tmr_en  = (state_q == GUARD_DRAIN) || (state_q == GUARD_RECOVER);
    end

    // Purpose: state register with synchronous reset into normal decoding.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GUARD_RUN;
        else        state_q <= state_d;
    end

    // Purpose: decoding is allowed in normal operation and while draining an access.
    always_comb begin
        pass_o  = (state_q == GUARD_RUN) || (state_q == GUARD_DRAIN);
        state_o = state_q;
    end

    // R5: an access that ends during drain leads straight to protection.
    assert_drain_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GUARD_DRAIN && ce_n_i) |=> (state_q == GUARD_LOCK));

    // R7: protection cannot be left while the power-fail flag is high.
    assert_lock_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GUARD_LOCK && pf_det_i) |=> (state_q == GUARD_LOCK));

    // R9: a power-fail during recovery returns to protection.
    assert_recover_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GUARD_RECOVER && pf_det_i) |=> (state_q == GUARD_LOCK));

    // R8: normal decoding is only reached from recovery when its interval has run out.
    assert_recover_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GUARD_RECOVER && !pf_det_i && !tmr_last) |=> (state_q == GUARD_RECOVER));

endmodule

// File: rtl/nvbank_bank_decode.sv
// Module: nvbank_bank_decode
// Combinational steering of the active-low chip-enable onto one bank output.
// Assumes: pass_i is a clean registered gate; no clock is needed here.
module nvbank_bank_decode #(
    parameter int NUM_BANKS = 4,
    parameter int SEL_W     = 2
) (
    input  logic                 pass_i,
    input  logic                 ce_n_i,
    input  logic [SEL_W-1:0]     sel_i,
    output logic [NUM_BANKS-1:0] ce_o_n
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Purpose: drive bank b low only when gated on, enabled and selected.
        always_comb begin
            ce_o_n[b] = !(pass_i && !ce_n_i && (sel_i == SEL_W'(b)));
        end
    end

endmodule

// File: rtl/nvbank_ce_guard.sv
// Module: nvbank_ce_guard (top)
// Decodes a chip-enable to one of NUM_BANKS banks and write-protects all banks on power-fail.
// Assumes: inputs synchronous to clk; WP_CYC and REC_CYC in clock cycles, both >= 1.
module nvbank_ce_guard
    import nvbank_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int WP_CYC    = 1000,
    parameter int REC_CYC   = 800000,
    localparam int SEL_W    = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pf_det_i,
    input  logic                 ce_n_i,
    input  logic [SEL_W-1:0]     sel_i,
    output logic [NUM_BANKS-1:0] ce_o_n
);

    logic         pass;
    guard_state_t state;

    nvbank_guard_fsm #(
        .WP_CYC  (WP_CYC),
        .REC_CYC (REC_CYC)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pf_det_i (pf_det_i),
        .ce_n_i   (ce_n_i),
        .pass_o   (pass),
        .state_o  (state)
    );

    nvbank_bank_decode #(
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W)
    ) dec_i (
        .pass_i (pass),
        .ce_n_i (ce_n_i),
        .sel_i  (sel_i),
        .ce_o_n (ce_o_n)
    );

    // R3: never more than one bank enabled.
    assert_single_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ce_o_n) <= 1);

    // R2: an idle enable input keeps every bank idle.
    assert_idle_all_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n_i |-> (&ce_o_n));

    // R4 / R7: protected or recovering states keep all banks off.
    assert_protect_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GUARD_LOCK || state == GUARD_RECOVER) |-> (&ce_o_n));

endmodule

// File: tb/nvbank_ce_guard_tb.sv
module nvbank_ce_guard_tb_top;

    localparam int  CLK_PERIOD = 10;
    localparam int  WP         = 6;
    localparam int  REC        = 10;
    localparam int  WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pf = 1'b0;
    logic       ce_n = 1'b1;
    logic [1:0] sel = 2'd0;
    logic [3:0] ce_o_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvbank_ce_guard #(
        .NUM_BANKS (4),
        .WP_CYC    (WP),
        .REC_CYC   (REC)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pf_det_i (pf),
        .ce_n_i   (ce_n),
        .sel_i    (sel),
        .ce_o_n   (ce_o_n)
    );

    // Expected outputs for an open decode path.
    function automatic logic [3:0] open_exp(input logic c, input logic [1:0] s);
        logic [3:0] v;
        v = 4'b1111;
        if (!c) v[s] = 1'b0;
        return v;
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        checks++;
        if (ce_o_n !== exp) begin
            fails++;
            $display("FAIL %s: ce_o_n=%b expected %b at %0t", req, ce_o_n, exp, $time);
        end
    endtask

    task automatic edge_then_settle();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic p, input logic c, input logic [1:0] s);
        @(negedge clk);
        pf = p; ce_n = c; sel = s;
        #1;
    endtask

    // Leave protection and wait out recovery fully.
    task automatic recover_full();
        drive(1'b0, 1'b1, 2'd0);
        repeat (REC + 1) edge_then_settle();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pf = 1'b0; ce_n = 1'b1;
        repeat (3) edge_then_settle();
        check("R10", 4'b1111);
        @(negedge clk); rst_n = 1'b1;
        drive(1'b0, 1'b0, 2'd2);
        check("R10", 4'b1011);
        drive(1'b0, 1'b1, 2'd2);
    endtask

    task automatic t_decode();
        for (int s = 0; s < 4; s++) begin
            drive(1'b0, 1'b0, 2'(s));
            check("R1", open_exp(1'b0, 2'(s)));
            edge_then_settle();
            checks++;
            if ($countones(~ce_o_n) > 1) begin
                fails++;
                $display("FAIL R3: ce_o_n=%b expected at most one low", ce_o_n);
            end
        end
        for (int s = 0; s < 4; s++) begin
            drive(1'b0, 1'b1, 2'(s));
            check("R2", 4'b1111);
        end
    endtask

    task automatic t_pf_idle();
        drive(1'b1, 1'b1, 2'd1);
        edge_then_settle();
        drive(1'b1, 1'b0, 2'd1);
        check("R4", 4'b1111);
        repeat (WP + 3) edge_then_settle();
        check("R7", 4'b1111);
        drive(1'b0, 1'b0, 2'd3);
        for (int k = 1; k <= REC; k++) begin
            edge_then_settle();
            check("R8", 4'b1111);
        end
        edge_then_settle();
        check("R8", 4'b0111);
        drive(1'b0, 1'b1, 2'd0);
    endtask

    task automatic t_pf_drain_short();
        drive(1'b0, 1'b0, 2'd0);
        drive(1'b1, 1'b0, 2'd0);
        for (int k = 1; k <= 3; k++) begin
            edge_then_settle();
            check("R5", 4'b1110);
        end
        drive(1'b1, 1'b1, 2'd0);
        edge_then_settle();
        drive(1'b1, 1'b0, 2'd0);
        check("R5", 4'b1111);
        edge_then_settle();
        check("R7", 4'b1111);
        recover_full();
    endtask

    task automatic t_pf_timeout();
        drive(1'b0, 1'b0, 2'd2);
        drive(1'b1, 1'b0, 2'd2);
        for (int k = 1; k <= WP; k++) begin
            edge_then_settle();
            if (k == WP) check("R6", 4'b1011);
        end
        edge_then_settle();
        check("R6", 4'b1111);
        recover_full();
    endtask

    task automatic t_pf_bounce();
        drive(1'b1, 1'b1, 2'd0);
        edge_then_settle();
        drive(1'b0, 1'b1, 2'd0);
        repeat (4) edge_then_settle();
        drive(1'b1, 1'b0, 2'd1);
        edge_then_settle();
        check("R9", 4'b1111);
        drive(1'b0, 1'b0, 2'd1);
        for (int k = 1; k <= REC; k++) begin
            edge_then_settle();
            if (k == REC) check("R9", 4'b1111);
        end
        edge_then_settle();
        check("R9", 4'b1101);
        drive(1'b0, 1'b1, 2'd0);
    endtask

    initial begin
        t_reset();
        t_decode();
        t_pf_idle();
        t_pf_drain_short();
        t_pf_timeout();
        t_pf_bounce();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: ends a hung run as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule